// File: doc/BRIEF.md
# Spread-spectrum modulation profile generator

This block is the digital heart of a spread-spectrum clock generator. It runs on the reference input clock and produces a signed frequency-offset code for the PLL. Downstream, that code would steer a current DAC or a fractional divider. The offset follows a triangle. Its peak-to-peak width equals the selected total spread.

Two spread styles are supported. Center spread swings the frequency evenly above and below the input frequency. Down spread only pulls the frequency below the input and never raises it.

The length of each triangle period is not constant. It walks linearly from a minimum to a maximum count of input clocks and back again, which smears the spectral peaks. The average period lands exactly on a nominal count.

Four static straps configure the block: spread style, depth, period range and an active-low enable. Any change on them restarts the modulation from the top of a fresh minimum-length period. A settled flag stays low for a fixed number of clocks after every change, so logic further down can wait out the PLL relock.

Top module: `ssc_profile_gen`

## Requirements
- R1: With center spread selected (`spread_down`=0) and modulation on, `offset` stays within ±10 units when `rate_hi`=0 and within ±30 units when `rate_hi`=1. It reaches both limits in every period. One unit is 0.05% of the nominal frequency.
- R2: With down spread selected (`spread_down`=1) and modulation on, `offset` is never positive. Its lower limit is −20 units when `rate_hi`=0 and −60 units when `rate_hi`=1. It touches both 0 and that lower limit in every period.
- R3: Within a period, `offset` starts at the upper limit and moves to the lower limit during the first half. It then moves back to the upper limit during the second half. It changes by at most one unit per clock. `phase_fall` is 1 during the first (falling) half and 0 during the second half.
- R4: The period lengths, in input clocks, depend on `period_sel`. The ranges are: 0 → 1920 to 2640; 1 → 3200 to 4400; 2 → 3840 to 5280; 3 → 6400 to 8800.
- R5: Successive periods are numbered 0 to 23, repeating. Period number i lasts min + k·(max−min)/12 clocks, where k = i for i ≤ 12 and k = 24−i otherwise. The mean over 24 periods is therefore the nominal count (2280, 3800, 4560 or 7600).
- R6: While `mod_en_n` is 1, `offset` is 0 and `phase_fall` is 0.
- R7: `settled` goes low on the clock after any strap input changes. It rises after SETTLE_CLKS clock edges with no further change. Every new change restarts this count.
- R8: After a strap change that leaves modulation on, the next clock begins period number 0 at the upper limit of the new window, with `phase_fall` high.
- R9: A synchronous active-high `rst` forces `offset` to 0 and clears the counters. After that edge `settled` is low, and it rises SETTLE_CLKS edges after `rst` is released.
- R10: Let t be the clock index within a period of length P, and H = P/2. S is the span (20 or 60), U is the upper limit and L = U − S. Then `offset` equals U − floor(t·S/H) for t < H, and L + floor((t−H)·S/H) for t ≥ H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_down | input | 1 | 0 selects center spread, 1 selects down spread |
| rate_hi | input | 1 | 0 selects the shallow depth, 1 the deep one |
| period_sel | input | 2 | Period range code, see R4 |
| mod_en_n | input | 1 | Modulation enable, active low |
| offset | output | 8 | Signed frequency offset in 0.05% units |
| phase_fall | output | 1 | High during the falling half of the triangle |
| settled | output | 1 | High once the settle interval has passed since the last strap change |

## Verification
The assertions assume the straps are quasi-static. Between changes they hold long enough for the window checks to describe one configuration. They also assume a change is seen as a difference between the strap pins and their registered copy, so the slope and window checks are suspended on the clock where that difference exists.

The stimulus changes straps only once per clock, right after the active edge. It holds each configuration for whole numbers of periods, except for one deliberate mid-period change and one burst of closely spaced changes. These exercise the restart and settle behaviour.

The bench model computes every expected offset from the closed-form floor expression, not from a running accumulator. Periods are measured purely from `phase_fall` edges.

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int SETTLE_CLKS = 64,
  parameter int HALF_STEPS  = 12,
  parameter int OFS_W       = 8,
  parameter int CNT_W       = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spread_down,
  input  logic                    rate_hi,
  input  logic [1:0]              period_sel,
  input  logic                    mod_en_n,
  output logic signed [OFS_W-1:0] offset,
  output logic                    phase_fall,
  output logic                    settled
);
  localparam int IDX_N = 2 * HALF_STEPS;
  localparam int IDX_W = $clog2(IDX_N);
  localparam int SET_W = $clog2(SETTLE_CLKS + 1);

  logic [4:0] cfg_in, cfg_q;
  logic       chg, off, dn, hi;

  assign cfg_in = {spread_down, rate_hi, period_sel, mod_en_n};
  assign chg    = cfg_in != cfg_q;
  assign off    = cfg_q[0];
  assign hi     = cfg_q[3];
  assign dn     = cfg_q[4];

  logic [CNT_W-1:0] t, acc, period, half, span;
  logic [OFS_W-1:0] pos;
  logic [IDX_W-1:0] idx;
  logic [SET_W-1:0] settle_cnt;
  int pmin, pstep, k, upper, lower;

  always_comb begin
    case (cfg_q[2:1])
      2'd0:    begin pmin = 1920; pstep = (2640 - 1920) / HALF_STEPS; end
      2'd1:    begin pmin = 3200; pstep = (4400 - 3200) / HALF_STEPS; end
      2'd2:    begin pmin = 3840; pstep = (5280 - 3840) / HALF_STEPS; end
      default: begin pmin = 6400; pstep = (8800 - 6400) / HALF_STEPS; end
    endcase
    k      = (int'(idx) <= HALF_STEPS) ? int'(idx) : IDX_N - int'(idx);
    period = CNT_W'(pmin + k * pstep);
    half   = period >> 1;
    span   = hi ? CNT_W'(60) : CNT_W'(20);
    upper  = dn ? 0 : int'(span) / 2;
    lower  = upper - int'(span);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= cfg_in;
      settle_cnt <= '0;
      t          <= '0;
      acc        <= '0;
      pos        <= '0;
      idx        <= '0;
    end else begin
      cfg_q <= cfg_in;
      if (chg)
        settle_cnt <= '0;
      else if (settle_cnt != SET_W'(SETTLE_CLKS))
        settle_cnt <= settle_cnt + SET_W'(1);

      if (chg || off) begin
        t   <= '0;
        acc <= '0;
        pos <= '0;
        idx <= '0;
      end else if (t == period - CNT_W'(1)) begin
        t   <= '0;
        acc <= '0;
        pos <= '0;
        idx <= (idx == IDX_W'(IDX_N - 1)) ? '0 : idx + IDX_W'(1);
      end else if (t == half - CNT_W'(1)) begin
        t   <= t + CNT_W'(1);
        acc <= '0;
        pos <= '0;
      end else begin
        t <= t + CNT_W'(1);
        if (acc + span >= half) begin
          acc <= acc + span - half;
          pos <= pos + OFS_W'(1);
        end else begin
          acc <= acc + span;
        end
      end
    end
  end

  assign offset     = (rst || off) ? '0 :
                      (t < half) ? OFS_W'(upper - int'(pos)) : OFS_W'(lower + int'(pos));
  assign phase_fall = !rst && !off && (t < half);
  assign settled    = settle_cnt == SET_W'(SETTLE_CLKS);

  a_r1_center_window: assert property (@(posedge clk) disable iff (rst)
    (!off && !dn) |-> (int'(offset) <= (hi ? 30 : 10) && int'(offset) >= (hi ? -30 : -10)));

  a_r2_down_window: assert property (@(posedge clk) disable iff (rst)
    (!off && dn) |-> (int'(offset) <= 0 && int'(offset) >= (hi ? -60 : -20)));

  a_r3_fall_slope: assert property (@(posedge clk) disable iff (rst)
    (!off && !chg && phase_fall) |=>
      (int'(offset) <= int'($past(offset)) && int'(offset) >= int'($past(offset)) - 1));

  a_r3_rise_slope: assert property (@(posedge clk) disable iff (rst)
    (!off && !chg && !phase_fall) |=>
      (int'(offset) >= int'($past(offset)) && int'(offset) <= int'($past(offset)) + 1));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    off |-> (offset == '0 && !phase_fall));

  a_r7_settle_drop: assert property (@(posedge clk) disable iff (rst)
    chg |=> !settled);

  a_r8_restart_top: assert property (@(posedge clk) disable iff (rst)
    (chg && !mod_en_n) |=> (phase_fall && int'(offset) == upper));
endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;
  localparam int SET = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, spread_down = 1'b0, rate_hi = 1'b0, mod_en_n = 1'b1;
  logic [1:0] period_sel = 2'd0;
  logic signed [7:0] offset;
  logic phase_fall, settled;

  ssc_profile_gen #(.SETTLE_CLKS(SET)) u_dut (
    .clk(clk), .rst(rst), .spread_down(spread_down), .rate_hi(rate_hi),
    .period_sel(period_sel), .mod_en_n(mod_en_n),
    .offset(offset), .phase_fall(phase_fall), .settled(settled));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_t = 0, m_idx = 0, m_set = 0;
  logic [4:0] m_cfg = 5'b00001;
  int omax, omin;
  int rise_q[$];
  bit prev_ph = 0;

  function automatic int per_of(input logic [1:0] sel, input int i);
    int lo, hi_, k;
    case (sel)
      2'd0: begin lo = 1920; hi_ = 2640; end
      2'd1: begin lo = 3200; hi_ = 4400; end
      2'd2: begin lo = 3840; hi_ = 5280; end
      default: begin lo = 6400; hi_ = 8800; end
    endcase
    k = (i <= 12) ? i : 24 - i;
    return lo + (k * (hi_ - lo)) / 12;
  endfunction

  function automatic int exp_off(input logic [4:0] c, input int t, input int i);
    int s, u, l, h;
    if (c[0]) return 0;
    s = c[3] ? 60 : 20;
    u = c[4] ? 0 : s / 2;
    l = u - s;
    h = per_of(c[2:1], i) / 2;
    if (t < h) return u - (t * s) / h;
    return l + ((t - h) * s) / h;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [4:0] cur;
    cur = {spread_down, rate_hi, period_sel, mod_en_n};
    if (rst) begin
      m_t = 0; m_idx = 0; m_set = 0; m_cfg = cur;
    end else if (cur != m_cfg) begin
      m_cfg = cur; m_t = 0; m_idx = 0; m_set = 0;
    end else begin
      if (m_set < SET) m_set++;
      if (m_cfg[0]) begin
        m_t = 0; m_idx = 0;
      end else begin
        m_t++;
        if (m_t == per_of(m_cfg[2:1], m_idx)) begin
          m_t = 0;
          m_idx = (m_idx + 1) % 24;
        end
      end
    end
  end

  always @(negedge clk) begin
    int eo, h;
    bit ep;
    cyc++;
    h  = per_of(m_cfg[2:1], m_idx) / 2;
    eo = rst ? 0 : exp_off(m_cfg, m_t, m_idx);
    ep = !rst && !m_cfg[0] && (m_t < h);
    check(int'(offset) == eo, "R10", "offset profile", int'(offset), eo);
    check(phase_fall == ep, "R3", "phase_fall", int'(phase_fall), int'(ep));
    check(settled == (m_set == SET), "R7", "settled", int'(settled), int'(m_set == SET));
    if (!rst) begin
      if (int'(offset) > omax) omax = int'(offset);
      if (int'(offset) < omin) omin = int'(offset);
      if (phase_fall && !prev_ph) rise_q.push_back(cyc);
      prev_ph = phase_fall;
    end
  end

  task automatic apply(input logic d, input logic h, input logic [1:0] s, input logic en_n);
    @(posedge clk); #1;
    spread_down = d; rate_hi = h; period_sel = s; mod_en_n = en_n;
    @(posedge clk); #1;
    omax = -1000; omin = 1000; rise_q.delete(); prev_ph = 0;
  endtask

  task automatic wait_rises(input int n);
    int guard = 0;
    while (rise_q.size() < n && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_periods(input logic [1:0] sel, input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      if (i + 1 < rise_q.size())
        check(rise_q[i+1] - rise_q[i] == per_of(sel, i), req, "period length",
              rise_q[i+1] - rise_q[i], per_of(sel, i));
      else
        check(0, req, "missing period edge", i, cnt);
    end
  endtask

  initial begin
    int n, sum, pmx, pmn;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(offset == 0, "R9", "offset in reset", int'(offset), 0);
    check(settled == 0, "R9", "settled in reset", int'(settled), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!settled && n < 1000);
    check(n == SET + 1, "R9", "clocks to settle after reset", n, SET + 1);

    // R1 R4 R5: center, shallow, shortest range, full sweep
    apply(1'b0, 1'b0, 2'd0, 1'b0);
    wait_rises(25);
    check_periods(2'd0, 24, "R5");
    sum = 0; pmx = 0; pmn = 100000;
    for (int i = 0; i < 24 && i + 1 < rise_q.size(); i++) begin
      sum += rise_q[i+1] - rise_q[i];
      if (rise_q[i+1] - rise_q[i] > pmx) pmx = rise_q[i+1] - rise_q[i];
      if (rise_q[i+1] - rise_q[i] < pmn) pmn = rise_q[i+1] - rise_q[i];
    end
    check(sum == 24 * 2280, "R5", "sweep total", sum, 24 * 2280);
    check(pmn == 1920, "R4", "shortest period", pmn, 1920);
    check(pmx == 2640, "R4", "longest period", pmx, 2640);
    check(omax == 10, "R1", "center shallow max", omax, 10);
    check(omin == -10, "R1", "center shallow min", omin, -10);

    // R2: down, deep, range 1
    apply(1'b1, 1'b1, 2'd1, 1'b0);
    wait_rises(4);
    check_periods(2'd1, 3, "R4");
    check(omax == 0, "R2", "down deep max", omax, 0);
    check(omin == -60, "R2", "down deep min", omin, -60);

    // R1: center, deep, range 2
    apply(1'b0, 1'b1, 2'd2, 1'b0);
    wait_rises(3);
    check_periods(2'd2, 2, "R4");
    check(omax == 30, "R1", "center deep max", omax, 30);
    check(omin == -30, "R1", "center deep min", omin, -30);

    // R2: down, shallow, range 3
    apply(1'b1, 1'b0, 2'd3, 1'b0);
    wait_rises(3);
    check_periods(2'd3, 2, "R4");
    check(omax == 0, "R2", "down shallow max", omax, 0);
    check(omin == -20, "R2", "down shallow min", omin, -20);

    // R6: modulation off
    apply(1'b0, 1'b1, 2'd0, 1'b1);
    repeat (300) @(negedge clk);
    check(omax == 0 && omin == 0, "R6", "offset while disabled", omax, 0);
    check(rise_q.size() == 0, "R6", "phase edges while disabled", rise_q.size(), 0);

    // R7 R8: mid-period change
    apply(1'b0, 1'b0, 2'd0, 1'b0);
    repeat (1000) @(negedge clk);
    check(settled == 1, "R7", "settled before change", int'(settled), 1);
    @(posedge clk); #1;
    rate_hi = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(settled == 0, "R7", "settled after change", int'(settled), 0);
    check(phase_fall == 1, "R8", "phase after restart", int'(phase_fall), 1);
    check(int'(offset) == 30, "R8", "offset after restart", int'(offset), 30);

    // R7: burst of changes keeps settled low
    for (int j = 0; j < 5; j++) begin
      repeat (20) @(posedge clk);
      #1 period_sel = period_sel + 2'd1;
      @(negedge clk);
      check(settled == 0, "R7", "settled during burst", int'(settled), 0);
    end
    n = 0;
    @(posedge clk); #1;
    period_sel = period_sel + 2'd1;
    do begin @(negedge clk); n++; end while (!settled && n < 1000);
    check(n == SET + 2, "R7", "clocks to settle after last change", n, SET + 2);

    // R9: reset mid-run
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(offset == 0, "R9", "offset after reset", int'(offset), 0);
    check(settled == 0, "R9", "settled after reset", int'(settled), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (10) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule